// File: doc/BRIEF.md
# Status Flag Bit Manipulator

This block holds an 8-bit processor status register. It applies single-bit operations to that register, one command per clock. A command can force any chosen flag to 1 or to 0. It can also move a bit between a general operand and the T flag, in either direction.

Store-to-T takes the chosen bit of the operand and places it in T. Load-from-T returns a copy of the operand in which the chosen bit has been replaced by T, and raises a write strobe so the register file can take the copy back. Each named flag has its own set and clear form. That form is the generic set or clear command with the flag's fixed index.

Flag changes that come from arithmetic are handled elsewhere and are not part of this block.

Top module: `status_bit_manip`

## Requirements
- R1: A synchronous active-high reset clears all eight status bits to 0 and drops the write strobe. The bit layout, from bit 7 down to bit 0, is I, T, H, S, V, N, Z, C.
- R2: Command code 1 (flag set) writes 1 to the status bit at position `idx` and leaves the other seven bits unchanged.
- R3: Command code 2 (flag clear) writes 0 to the status bit at position `idx` and leaves the other seven bits unchanged.
- R4: Command code 3 (store to T) copies bit `idx` of `opnd` into T (bit 6). It changes no other status bit and does not raise the write strobe.
- R5: Command code 4 (load from T) outputs `opnd` with bit `idx` replaced by the current T, and asserts `res_we`. The status register is left unchanged.
- R6: `res_we` is high only in the cycle that follows a load-from-T command.
- R7: Command code 0 and the unused codes 5, 6 and 7 change neither the status register nor the strobe.
- R8: Every command takes effect in a single clock. The status register and the result are visible after the first rising edge that samples the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Command code |
| idx | input | IDX_W | Flag or bit index |
| opnd | input | OPND_W | Register operand |
| sreg | output | 8 | Status register |
| res | output | OPND_W | Operand with T inserted |
| res_we | output | 1 | Result write strobe |

## Verification
The bench builds the block with its default operand width of 8, so `idx` spans exactly the eight status positions. At that width, every flag position and every operand bit can be reached by the same index field. Top-bit and bottom-bit inserts are therefore exercised, along with set and clear on a flag that already holds the target value.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int SREG_W = 8;

    // Status bit positions
    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_S = 4;
    localparam int FLAG_H = 5;
    localparam int FLAG_T = 6;
    localparam int FLAG_I = 7;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_FSET  = 3'd1,
        OP_FCLR  = 3'd2,
        OP_TSTO  = 3'd3,
        OP_TLOAD = 3'd4
    } op_e;

    typedef logic [SREG_W-1:0] sreg_t;

    function automatic sreg_t put_bit(sreg_t v, logic [2:0] pos, logic b);
        sreg_t r;
        r = v;
        r[pos] = b;
        return r;
    endfunction

endpackage

// File: rtl/sbm_flag_unit.sv
module sbm_flag_unit
    import sbm_pkg::*;
(
    input  logic [2:0] op,
    input  logic [2:0] fidx,
    input  logic       t_in,
    input  sreg_t      cur,
    output sreg_t      nxt
);
    always_comb begin
        case (op)
            OP_FSET: nxt = put_bit(cur, fidx, 1'b1);
            OP_FCLR: nxt = put_bit(cur, fidx, 1'b0);
            OP_TSTO: nxt = put_bit(cur, 3'(FLAG_T), t_in);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/sbm_bit_bridge.sv
module sbm_bit_bridge #(
    parameter int OPND_W = 8,
    parameter int IDX_W  = $clog2(OPND_W)
) (
    input  logic [OPND_W-1:0] opnd,
    input  logic [IDX_W-1:0]  idx,
    input  logic              t_flag,
    output logic              picked,
    output logic [OPND_W-1:0] merged
);
    always_comb begin
        picked      = opnd[idx];
        merged      = opnd;
        merged[idx] = t_flag;
    end
endmodule

// File: rtl/status_bit_manip.sv
module status_bit_manip
    import sbm_pkg::*;
#(
    parameter int OPND_W = 8,
    parameter int IDX_W  = $clog2(OPND_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OPND_W-1:0] opnd,
    output logic [7:0]        sreg,
    output logic [OPND_W-1:0] res,
    output logic              res_we
);
    sreg_t              sreg_q, sreg_d;
    logic               picked;
    logic [OPND_W-1:0]  merged;
    logic [2:0]         fidx;

    assign fidx = idx[2:0];

    sbm_bit_bridge #(.OPND_W(OPND_W), .IDX_W(IDX_W)) u_bridge (
        .opnd   (opnd),
        .idx    (idx),
        .t_flag (sreg_q[FLAG_T]),
        .picked (picked),
        .merged (merged)
    );

    sbm_flag_unit u_flags (
        .op   (op),
        .fidx (fidx),
        .t_in (picked),
        .cur  (sreg_q),
        .nxt  (sreg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            res    <= '0;
            res_we <= 1'b0;
        end else begin
            sreg_q <= sreg_d;
            res_we <= (op == OP_TLOAD);
            if (op == OP_TLOAD)
                res <= merged;
        end
    end

    assign sreg = sreg_q;

    AST_SET_WRITES_ONE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_FSET) |-> sreg[$past(fidx)] == 1'b1); // R2

    AST_CLR_WRITES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_FCLR) |-> sreg[$past(fidx)] == 1'b0); // R3

    AST_STORE_ONLY_T: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_TSTO) |->
        (sreg[FLAG_T] == $past(opnd[idx]) && (sreg & 8'hBF) == ($past(sreg) & 8'hBF)
         && !res_we)); // R4

    AST_LOAD_KEEPS_SREG: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op) == OP_TLOAD) |->
        (sreg == $past(sreg) && res_we && res[$past(idx)] == $past(sreg[FLAG_T]))); // R5

    AST_STROBE_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (!$past(rst) && $past(op) == OP_TLOAD)); // R6

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op) == 3'd0 || $past(op) > 3'd4)) |->
        (sreg == $past(sreg) && !res_we)); // R7
endmodule

// File: tb/test_status_bit_manip.sv
module test_status_bit_manip;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op;
    logic [2:0] idx;
    logic [7:0] opnd;
    logic [7:0] sreg;
    logic [7:0] res;
    logic       res_we;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_bit_manip i_status_bit_manip (
        .clk(clk), .rst(rst), .op(op), .idx(idx), .opnd(opnd),
        .sreg(sreg), .res(res), .res_we(res_we)
    );

    // {op, idx, opnd, expected sreg, expected strobe, expected res}
    localparam logic [30:0] VEC [NVEC] = '{
        {3'd1, 3'd0, 8'h00, 8'h01, 1'b0, 8'h00},  // R2
        {3'd1, 3'd7, 8'h00, 8'h81, 1'b0, 8'h00},  // R2
        {3'd1, 3'd3, 8'h00, 8'h89, 1'b0, 8'h00},  // R2
        {3'd2, 3'd0, 8'h00, 8'h88, 1'b0, 8'h00},  // R3
        {3'd3, 3'd5, 8'h20, 8'hC8, 1'b0, 8'h00},  // R4
        {3'd4, 3'd2, 8'h00, 8'hC8, 1'b1, 8'h04},  // R5
        {3'd3, 3'd5, 8'hDF, 8'h88, 1'b0, 8'h00},  // R4
        {3'd4, 3'd7, 8'hFF, 8'h88, 1'b1, 8'h7F},  // R5
        {3'd5, 3'd1, 8'hFF, 8'h88, 1'b0, 8'h00},  // R7
        {3'd2, 3'd7, 8'h00, 8'h08, 1'b0, 8'h00},  // R3
        {3'd1, 3'd6, 8'h00, 8'h48, 1'b0, 8'h00},  // R2
        {3'd4, 3'd0, 8'hA4, 8'h48, 1'b1, 8'hA5},  // R5
        {3'd2, 3'd6, 8'h00, 8'h08, 1'b0, 8'h00},  // R3
        {3'd1, 3'd3, 8'h00, 8'h08, 1'b0, 8'h00},  // R2
        {3'd2, 3'd5, 8'h00, 8'h08, 1'b0, 8'h00}   // R3
    };

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic [2:0] o, logic [2:0] i, logic [7:0] d);
        op = o; idx = i; opnd = d;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op = 3'd0; idx = 3'd0; opnd = 8'h00;
        @(negedge clk); @(negedge clk);
        check8("R1 sreg", sreg, 8'h00);
        check8("R1 strobe", {7'd0, res_we}, 8'h00);
        rst = 1'b0;

        // R8: each result is sampled one edge after its command
        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][30:28], VEC[k][27:25], VEC[k][24:17]);
            check8($sformatf("R8 vec%0d sreg", k), sreg, VEC[k][16:9]);
            check8($sformatf("R6 vec%0d strobe", k), {7'd0, res_we}, {7'd0, VEC[k][8]});
            if (VEC[k][8])
                check8($sformatf("R5 vec%0d res", k), res, VEC[k][7:0]);
        end

        // R6: strobe drops after an idle command
        step(3'd0, 3'd0, 8'h00);
        check8("R6 strobe low after idle", {7'd0, res_we}, 8'h00);
        check8("R7 idle keeps sreg", sreg, 8'h08);

        // R7: codes 6 and 7 ignored
        step(3'd6, 3'd3, 8'hFF);
        check8("R7 code6", sreg, 8'h08);
        step(3'd7, 3'd2, 8'hFF);
        check8("R7 code7", sreg, 8'h08);
        check8("R7 code7 strobe", {7'd0, res_we}, 8'h00);

        // Every flag set, then mid-run reset
        for (int b = 0; b < 8; b++) step(3'd1, 3'(b), 8'h00);
        check8("R2 all flags", sreg, 8'hFF);
        step(3'd4, 3'd4, 8'h00);
        check8("R5 insert T=1", res, 8'h10);
        rst = 1'b1;
        step(3'd4, 3'd1, 8'h00);
        check8("R1 mid reset sreg", sreg, 8'h00);
        check8("R1 mid reset strobe", {7'd0, res_we}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule